// File: doc/BRIEF.md
# Chained Selector Update Sequencer

This block sits on the host side of a serial chain of eight-way analog selectors that share one clock line, one select line and one data line. Each selector holds a 4-bit control word. The host asks for one global channel, or for every channel off. The block turns that request into one word per device, shifts the words out as a single frame, and then commits them all at the same moment by lowering the select line.

The caller sees a plain request/busy/done handshake. A request carries a global channel index and an all-off flag. An index beyond the last channel of the chain is handled as an all-off request and raises an error flag. The serial clock comes from the system clock through a programmable divider. The done pulse is delayed by a settle time after the commit, so that the analog path has time to switch.

Top module: `chain_mux_sequencer`

## Requirements
- R1: After reset, busy, done, err, ser_clk, ser_cs and ser_din are all 0.
- R2: Each device word is four bits sent enable bit first, then a 3-bit channel code, most significant bit first. Device k (k = 0 is wired to ser_din) owns global channels 8k to 8k+7. Its code is the index's low three bits when it is the target and 000 otherwise.
- R3: For an in-range index, exactly one word in the frame has enable 1. For an all-off request, every word has enable 0.
- R4: The word for the device farthest from the host (k = NUM_DEV-1) is shifted first, and the word for device 0 is shifted last.
- R5: ser_cs stays high for the whole shift, and ser_clk rises exactly 4·NUM_DEV times while ser_cs is high. ser_din changes only while ser_clk is low.
- R6: ser_cs falls after the last rising edge and before any further rising edge. ser_clk is never high while ser_cs is low.
- R7: Each high phase of ser_clk lasts HALF_DIV system cycles.
- R8: done is a one-cycle pulse that rises SETTLE_CYC cycles after ser_cs falls. busy is high from the cycle after a request is accepted until done.
- R9: A request raised while busy is ignored and does not change the update in progress.
- R10: An index of 8·NUM_DEV or more sends all-off and sets err. err holds its value until the next accepted request. An all-off request clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_index | input | IDX_W | Global channel index |
| req_all_off | input | 1 | Request every channel off |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last accepted index was out of range |
| ser_clk | output | 1 | Serial clock to the chain |
| ser_cs | output | 1 | Serial select, high while shifting |
| ser_din | output | 1 | Serial data to the first device |

## Verification
The hardest case to produce from the ports is a request that arrives in the middle of a shift. The bench raises a second strobe with a different index while busy is high. It then checks that the committed words of the chain model still match the first request. Device placement is observed through a bit-level model of the whole chain. The model shifts on ser_clk and latches on the falling edge of ser_cs. Sweeping every index from 0 to 63 therefore covers each device, each code, the out-of-range region and the word order at the same time.

// File: rtl/chain_mux_pkg.sv
package chain_mux_pkg;

    localparam int WORD_W  = 4;
    localparam int CODE_W  = 3;
    localparam int PER_DEV = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_SETTLE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/chain_mux_pacer.sv
module chain_mux_pacer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = 1'b0;
        cnt_d = '0;
        if (run) begin
            if (cnt_q == CNT_W'(HALF_DIV - 1)) begin
                tick  = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r7_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick && HALF_DIV > 1 |=> !tick);

endmodule

// File: rtl/chain_mux_framer.sv
module chain_mux_framer
    import chain_mux_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter int IDX_W   = 6
) (
    input  logic [IDX_W-1:0]          index,
    input  logic                      all_off,
    output logic [NUM_DEV*WORD_W-1:0] frame,
    output logic [NUM_DEV-1:0]        enables,
    output logic                      out_of_range
);
    localparam int TOTAL_CH = NUM_DEV * PER_DEV;
    localparam int DEV_W    = IDX_W - CODE_W;

    logic in_range;
    assign in_range     = ({1'b0, index} < (IDX_W+1)'(TOTAL_CH));
    assign out_of_range = !all_off && !in_range;

    for (genvar k = 0; k < NUM_DEV; k++) begin : g_word
        logic hit;
        assign hit        = !all_off && in_range && (index[IDX_W-1:CODE_W] == DEV_W'(k));
        assign enables[k] = hit;
        assign frame[k*WORD_W +: WORD_W] = hit ? {1'b1, index[CODE_W-1:0]} : '0;
    end

    always_comb begin
        a_r3_one_enable: assert ($onehot0(enables));
    end

endmodule

// File: rtl/chain_mux_sequencer.sv
module chain_mux_sequencer
    import chain_mux_pkg::*;
#(
    parameter int NUM_DEV    = 2,
    parameter int IDX_W      = 6,
    parameter int HALF_DIV   = 2,
    parameter int SETTLE_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_index,
    input  logic             req_all_off,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             ser_clk,
    output logic             ser_cs,
    output logic             ser_din
);
    localparam int FRAME_W = NUM_DEV * WORD_W;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int SET_W   = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [BIT_W-1:0] bit_cnt;
        logic [SET_W-1:0] settle_cnt;
        logic [FRAME_W-1:0] shreg;
        logic             sclk;
        logic             cs;
        logic             done;
        logic             err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [FRAME_W-1:0] new_frame;
    logic [NUM_DEV-1:0] new_en;
    logic               new_oor;
    logic               tick;

    chain_mux_framer #(
        .NUM_DEV(NUM_DEV),
        .IDX_W  (IDX_W)
    ) i_framer (
        .index       (req_index),
        .all_off     (req_all_off),
        .frame       (new_frame),
        .enables     (new_en),
        .out_of_range(new_oor)
    );

    chain_mux_pacer #(
        .HALF_DIV(HALF_DIV)
    ) i_pacer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (r_q.st == ST_SHIFT),
        .tick (tick)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st      = ST_SHIFT;
                    r_d.shreg   = new_frame;
                    r_d.err     = new_oor;
                    r_d.bit_cnt = '0;
                    r_d.cs      = 1'b1;
                    r_d.sclk    = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.bit_cnt == BIT_W'(FRAME_W - 1)) begin
                            r_d.st         = ST_SETTLE;
                            r_d.cs         = 1'b0;
                            r_d.settle_cnt = '0;
                            r_d.shreg      = '0;
                        end else begin
                            r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                            r_d.shreg   = {r_q.shreg[FRAME_W-2:0], 1'b0};
                        end
                    end
                end
            end
            ST_SETTLE: begin
                if (r_q.settle_cnt == SET_W'(SETTLE_CYC - 1)) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.settle_cnt = r_q.settle_cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign err     = r_q.err;
    assign ser_clk = r_q.sclk;
    assign ser_cs  = r_q.cs;
    assign ser_din = r_q.cs & r_q.shreg[FRAME_W-1];

    a_r5_cs_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> ser_cs);

    a_r5_din_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk && $past(ser_clk) |-> $stable(ser_din));

    a_r6_no_clk_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_cs |-> !ser_clk);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !ser_cs);

    a_r9_busy_holds_cs: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ser_cs && req_valid |=> busy);

endmodule

// File: tb/test_chain_mux_sequencer.sv
`timescale 1ns/1ps
module test_chain_mux_sequencer;
    localparam int NUM_DEV    = 2;
    localparam int IDX_W      = 6;
    localparam int HALF_DIV   = 2;
    localparam int SETTLE_CYC = 3;
    localparam int NBITS      = NUM_DEV * 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [IDX_W-1:0] req_index = '0;
    logic req_all_off = 1'b0;
    logic busy, done, err, ser_clk, ser_cs, ser_din;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    chain_mux_sequencer #(
        .NUM_DEV(NUM_DEV), .IDX_W(IDX_W), .HALF_DIV(HALF_DIV), .SETTLE_CYC(SETTLE_CYC)
    ) i_chain_mux_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
        .req_all_off(req_all_off), .busy(busy), .done(done), .err(err),
        .ser_clk(ser_clk), .ser_cs(ser_cs), .ser_din(ser_din)
    );

    // chain model: device 0 takes ser_din, each later device takes the previous MSB
    logic [3:0] sr  [NUM_DEV];
    logic [3:0] lat [NUM_DEV];
    int rises = 0;
    int bad_rise = 0;
    int committed_rises = -1;

    initial for (int k = 0; k < NUM_DEV; k++) begin sr[k] = '0; lat[k] = '0; end

    always @(posedge ser_clk) begin
        if (ser_cs) begin
            rises <= rises + 1;
            for (int k = 0; k < NUM_DEV; k++)
                sr[k] <= {sr[k][2:0], (k == 0) ? ser_din : sr[(k == 0) ? 0 : k-1][3]};
        end else begin
            bad_rise <= bad_rise + 1;
        end
    end

    always @(posedge ser_cs) rises <= 0;

    always @(negedge ser_cs) begin
        committed_rises <= rises;
        for (int k = 0; k < NUM_DEV; k++) lat[k] <= sr[k];
    end

    // phase monitor sampled away from the active edge
    int hi_run = 0;
    int bad_hi = 0;
    int bad_din = 0;
    logic prev_sclk = 1'b0;
    logic prev_din  = 1'b0;
    always @(negedge clk) begin
        if (ser_clk) begin
            hi_run <= hi_run + 1;
            if (prev_sclk && ser_din !== prev_din) bad_din <= bad_din + 1;
        end else if (prev_sclk) begin
            if (hi_run != HALF_DIV) bad_hi <= bad_hi + 1;
            hi_run <= 0;
        end
        prev_sclk <= ser_clk;
        prev_din  <= ser_din;
    end

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    int settle_seen;
    int timeouts = 0;

    task automatic run_req(input int idx, input bit off, input bit poke_busy);
        int waited;
        bit saw_cs;
        @(negedge clk);
        req_index   = IDX_W'(idx);
        req_all_off = off;
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid   = 1'b0;
        check("R8 busy after accept", busy, 1);
        waited = 0; saw_cs = 0; settle_seen = 0;
        while (!done && waited < 2000) begin
            if (ser_cs) saw_cs = 1;
            else if (saw_cs) settle_seen++;
            if (poke_busy && waited == 5) begin
                req_index   = IDX_W'((idx + 9) % (NUM_DEV * 8));
                req_all_off = 1'b0;
                req_valid   = 1'b1;
            end else begin
                req_valid   = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        req_valid = 1'b0;
        if (!done) begin
            timeouts++;
            check("R8 done within limit", 0, 1);
        end
        check("R8 settle cycles", settle_seen, SETTLE_CYC);
        check("R8 busy low at done", busy, 0);
        @(negedge clk);
        check("R8 done one cycle", done, 0);
    endtask

    task automatic verify(input int idx, input bit off, input string tag);
        bit valid;
        int dev;
        valid = !off && (idx < NUM_DEV * 8);
        dev   = idx / 8;
        for (int k = 0; k < NUM_DEV; k++) begin
            int exp_word;
            exp_word = (valid && k == dev) ? (8 + idx % 8) : 0;
            check({tag, " R2 R3 R4 word"}, int'(lat[k]), exp_word);
        end
        check("R10 err flag", err, (!off && idx >= NUM_DEV * 8) ? 1 : 0);
        check("R5 rising edges in frame", committed_rises, NBITS);
        check("R6 no rise with cs low", bad_rise, 0);
        check("R7 high phase length", bad_hi, 0);
        check("R5 din steady while high", bad_din, 0);
    endtask

    initial begin
        #2000000;
        $display("FAIL watchdog expired actual=hung expected=finish");
        n_fail++;
        n_checks++;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 err", err, 0);
        check("R1 ser_clk", ser_clk, 0);
        check("R1 ser_cs", ser_cs, 0);
        check("R1 ser_din", ser_din, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // sweep every index, covering every device, code and out-of-range value
        for (int i = 0; i < (1 << IDX_W); i++) begin
            run_req(i, 1'b0, 1'b0);
            verify(i, 1'b0, (i >= NUM_DEV * 8) ? "R10" : "sweep");
        end

        // all-off after an error: every word disabled, err cleared (R3, R10)
        run_req(5, 1'b1, 1'b0);
        verify(5, 1'b1, "R3 all-off");

        // R9: a request raised mid-shift must not alter the update
        run_req(3, 1'b0, 1'b1);
        verify(3, 1'b0, "R9 busy request");
        run_req(12, 1'b0, 1'b1);
        verify(12, 1'b0, "R9 busy request");

        // R4: the last device ends up with the target, earlier devices cleared
        run_req(NUM_DEV * 8 - 1, 1'b0, 1'b0);
        verify(NUM_DEV * 8 - 1, 1'b0, "R4 last device");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule